// File: doc/BRIEF.md
# Pin Bank Register Block with Function Select

This block is a register file for a bank of 54 general-purpose pins, reached over a simple 32-bit register bus. Each pin carries a 3-bit function code. Software uses it to choose what each pin does, to drive pin levels, and to read the level state back. A shared level state is changed only through write-one-to-set and write-one-to-clear ports. A pin's registered output line follows that state only while the pin is coded as an output, and only when a write really changes its level bit.

The block also watches the function codes of pins 48 to 53 and drives a sticky one-bit route selector. This selector decides which of two host controllers owns a storage-card bus. Register slots for edge detection, level detection and pull control are decoded but have no effect. Any other slot in the window is flagged as a bad access.

Top module: `pinbank_regs`

## Requirements
- R1: Pin p's 3-bit code lives in select word p/10, at offset 4*(p/10) (words at 0x00 to 0x14), bits [3*(p mod 10)+2 : 3*(p mod 10)]. Fields for pins above 53 and bits 31:30 of every select word read as 0, and writes to them are dropped.
- R2: A write to 0x1C (pins 0-31) or 0x20 (pins 32-53, bit k is pin 32+k) sets each level bit written as 1. A write to 0x28 or 0x2C, with the same bit mapping, clears each level bit written as 1. This happens whatever the pin's code. Bits 31:22 of the upper bank writes are ignored, and all four ports read as 0.
- R3: Reads of 0x34 return the level of pins 0-31. Reads of 0x38 return pins 32-53 in bits 21:0, with bits 31:22 as 0. Writes to either address change nothing.
- R4: An output line moves only on a set or clear write that changes the pin's level bit while the pin's code is 1. A set drives it to 1 and a clear drives it to 0. Otherwise the line holds its value. The output is updated at the same clock edge as the level bit.
- R5: Offsets 0x40, 0x44, 0x4C, 0x50, 0x58, 0x5C, 0x64, 0x68, 0x70, 0x74, 0x7C, 0x80, 0x88, 0x8C, 0x94, 0x98 and 0x9C read as 0, ignore writes and raise no error.
- R6: Any other offset, including an address that is not word-aligned, is bad. A read returns 0, a write changes nothing, and `bus_err` is high for exactly the cycle after the access.
- R7: After every select-word write, the route is evaluated against the codes now stored for pins 48-53. If all six are 0, `card_route` becomes 0 (controller A). If all six are 4, it becomes 1 (controller B). Any mixed pattern leaves it unchanged. The new value appears two clock edges after the write edge.
- R8: Reset clears all codes, all level bits and all output lines to 0, and sets `card_route` to 0.
- R9: `bus_rdata` carries the addressed value in the cycle after a `bus_rd` cycle and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| pin_out | output | 54 | Registered pin output lines |
| card_route | output | 1 | Card bus owner: 0 controller A, 1 controller B |

## Verification
On every cycle, the checker confirms four things. An output line rises only after a set-port write and falls only after a clear-port write, and it stays still when no such write occurs. The route changes only two edges after a select-word write. Read data is zero outside read responses, and every error pulse follows a bad access. Only the scenarios can show the values themselves:
- the packing of codes into select words;
- that a set on a pin already at 1 leaves its output alone;
- the masking of the upper bank;
- that the route is sticky through mixed patterns;
- that ignored writes to level, inert and bad offsets truly leave the state untouched.

// File: rtl/pinbank_pkg.sv
// Shared constants, access classes and the offset decoder for the pin bank.
// Assumes word-aligned 32-bit accesses; anything unaligned is a bad access.
package pinbank_pkg;

    parameter int unsigned DATA_W       = 32;
    parameter int unsigned CODE_W       = 3;
    parameter int unsigned PINS_PER_REG = 10;
    parameter int unsigned OUT_CODE     = 1;

    typedef enum logic [3:0] {
        ACC_FUNC,
        ACC_SET0,
        ACC_SET1,
        ACC_CLR0,
        ACC_CLR1,
        ACC_LEV0,
        ACC_LEV1,
        ACC_INERT,
        ACC_BAD
    } acc_kind_e;

    // Map a byte offset onto its access class.
    function automatic acc_kind_e classify(input logic [31:0] off, input int unsigned n_func);
        if (off[1:0] != 2'b00) return ACC_BAD;
        if (off < 32'(4 * n_func)) return ACC_FUNC;
        case (off)
            32'h1C: return ACC_SET0;
            32'h20: return ACC_SET1;
            32'h28: return ACC_CLR0;
            32'h2C: return ACC_CLR1;
            32'h34: return ACC_LEV0;
            32'h38: return ACC_LEV1;
            32'h40, 32'h44, 32'h4C, 32'h50, 32'h58, 32'h5C, 32'h64,
            32'h68, 32'h70, 32'h74, 32'h7C, 32'h80, 32'h88, 32'h8C,
            32'h94, 32'h98, 32'h9C: return ACC_INERT;
            default: return ACC_BAD;
        endcase
    endfunction

endpackage

// File: rtl/pinbank_codes.sv
// Function-code storage: one CODE_W field per pin, PINS_PER_REG pins per word.
// Assumes reg_idx addresses a valid select word whenever wr_en is high.
module pinbank_codes
    import pinbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned IDX_W    = 3,
    localparam int unsigned FIELD_W = CODE_W * PINS_PER_REG
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             reg_idx,
    input  logic [FIELD_W-1:0]           wdata,
    output logic [DATA_W-1:0]            rd_word,
    output logic [NUM_PINS*CODE_W-1:0]   codes_flat
);

    logic [CODE_W-1:0] code_q [NUM_PINS];
    int                base;

    assign base = int'(reg_idx) * int'(PINS_PER_REG);

    // Store the fields of the addressed word; fields past the last pin are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < int'(NUM_PINS); p++) code_q[p] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(PINS_PER_REG); i++)
                if (base + i < int'(NUM_PINS))
                    code_q[base + i] <= wdata[CODE_W*i +: CODE_W];
        end
    end

    // Assemble the addressed word; missing fields and top bits stay zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < int'(PINS_PER_REG); i++)
            if (base + i < int'(NUM_PINS))
                rd_word[CODE_W*i +: CODE_W] = code_q[base + i];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_flat
        assign codes_flat[p*CODE_W +: CODE_W] = code_q[p];
    end

endmodule

// File: rtl/pinbank_level.sv
// Level state and registered output lines, changed by set/clear strobes.
// Assumes at most one of set_en/clr_en is high; bank_hi picks pins 32 and up.
module pinbank_level
    import pinbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic                        clr_en,
    input  logic                        bank_hi,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NUM_PINS*CODE_W-1:0]  codes_flat,
    output logic [NUM_PINS-1:0]         level,
    output logic [NUM_PINS-1:0]         pin_out
);

    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] is_out;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam bit          UPPER = (p / DATA_W) != 0;
        localparam int unsigned BIT   = p % DATA_W;
        assign hit[p]    = (bank_hi == UPPER) && wdata[BIT];
        assign is_out[p] = codes_flat[p*CODE_W +: CODE_W] == CODE_W'(OUT_CODE);
    end

    // Level bits follow every set/clear regardless of function code.
    always_ff @(posedge clk) begin
        if (!rst_n)       level <= '0;
        else if (set_en)  level <= level | hit;
        else if (clr_en)  level <= level & ~hit;
    end

    // Output lines move only on a real level change of an output-coded pin.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_out <= '0;
        else if (set_en)  pin_out <= pin_out | (hit & ~level & is_out);
        else if (clr_en)  pin_out <= pin_out & ~(hit & level & is_out);
    end

endmodule

// File: rtl/pinbank_route.sv
// Sticky two-way card-bus route chosen by a uniform code on a group of pins.
// Assumes eval pulses once after each select-word write.
module pinbank_route
    import pinbank_pkg::*;
#(
    parameter int unsigned COUNT  = 6,
    parameter int unsigned CODE_A = 0,
    parameter int unsigned CODE_B = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     eval,
    input  logic [COUNT*CODE_W-1:0]  codes_sel,
    output logic                     route_b
);

    logic [COUNT-1:0] is_a;
    logic [COUNT-1:0] is_b;

    for (genvar k = 0; k < COUNT; k++) begin : g_cmp
        assign is_a[k] = codes_sel[k*CODE_W +: CODE_W] == CODE_W'(CODE_A);
        assign is_b[k] = codes_sel[k*CODE_W +: CODE_W] == CODE_W'(CODE_B);
    end

    // Switch only on a uniform pattern; mixed patterns keep the route.
    always_ff @(posedge clk) begin
        if (!rst_n)                          route_b <= 1'b0;
        else if (eval && route_b && &is_a)   route_b <= 1'b0;
        else if (eval && !route_b && &is_b)  route_b <= 1'b1;
    end

endmodule

// File: rtl/pinbank_regs.sv
// Pin bank register block top: decodes bus offsets, registers read data and
// error pulses, and ties together codes, level state and the card route.
// Assumes one access per cycle, never bus_wr and bus_rd together.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 54,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned ROUTE_FIRST = 48,
    parameter int unsigned ROUTE_COUNT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                card_route
);

    localparam int unsigned N_REGS  = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;
    localparam int unsigned IDX_W   = $clog2(N_REGS);
    localparam int unsigned FIELD_W = CODE_W * PINS_PER_REG;

    acc_kind_e                  kind;
    logic [DATA_W-1:0]          code_word;
    logic [DATA_W-1:0]          rd_mux;
    logic [NUM_PINS*CODE_W-1:0] codes_flat;
    logic [NUM_PINS-1:0]        level;
    logic                       eval_q;
    logic                       set_en, clr_en, bank_hi, func_wr;

    assign kind    = classify(32'(bus_addr), N_REGS);
    assign func_wr = bus_wr && kind == ACC_FUNC;
    assign set_en  = bus_wr && (kind == ACC_SET0 || kind == ACC_SET1);
    assign clr_en  = bus_wr && (kind == ACC_CLR0 || kind == ACC_CLR1);
    assign bank_hi = kind == ACC_SET1 || kind == ACC_CLR1;

    pinbank_codes #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_codes (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (func_wr),
        .reg_idx    (bus_addr[IDX_W+1:2]),
        .wdata      (bus_wdata[FIELD_W-1:0]),
        .rd_word    (code_word),
        .codes_flat (codes_flat)
    );

    pinbank_level #(.NUM_PINS(NUM_PINS)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .clr_en     (clr_en),
        .bank_hi    (bank_hi),
        .wdata      (bus_wdata),
        .codes_flat (codes_flat),
        .level      (level),
        .pin_out    (pin_out)
    );

    pinbank_route #(.COUNT(ROUTE_COUNT)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval       (eval_q),
        .codes_sel  (codes_flat[ROUTE_FIRST*CODE_W +: ROUTE_COUNT*CODE_W]),
        .route_b    (card_route)
    );

    // Select the read value; write-only, inert and bad slots give zero.
    always_comb begin
        rd_mux = '0;
        case (kind)
            ACC_FUNC: rd_mux = code_word;
            ACC_LEV0: rd_mux = level[DATA_W-1:0];
            ACC_LEV1: rd_mux = DATA_W'(level[NUM_PINS-1:DATA_W]);
            default:  rd_mux = '0;
        endcase
    end

    // Register read data, the bad-access pulse and the route evaluation strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            eval_q    <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
            bus_err   <= (bus_rd || bus_wr) && kind == ACC_BAD;
            eval_q    <= func_wr;
        end
    end

endmodule

// File: rtl/pinbank_regs_chk.sv
// Cycle-level properties of the pin bank, bound to the top module.
// Assumes the same offset map as the design through the shared decoder.
module pinbank_regs_chk
    import pinbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_err,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                card_route
);

    localparam int unsigned N_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

    acc_kind_e kind;
    logic      w_set, w_clr, w_func, a_bad;

    assign kind   = classify(32'(bus_addr), N_REGS);
    assign w_set  = bus_wr && (kind == ACC_SET0 || kind == ACC_SET1);
    assign w_clr  = bus_wr && (kind == ACC_CLR0 || kind == ACC_CLR1);
    assign w_func = bus_wr && kind == ACC_FUNC;
    assign a_bad  = (bus_wr || bus_rd) && kind == ACC_BAD;

    // R4: no set/clear write, no output movement
    assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_set || w_clr) |=> $stable(pin_out));

    // R4: an output rises only after a set-port write
    assert_out_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pin_out & ~$past(pin_out))) |-> $past(w_set));

    // R4: an output falls only after a clear-port write
    assert_out_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~pin_out & $past(pin_out))) |-> $past(w_clr));

    // R7: the route changes only two edges after a select-word write
    assert_route_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_route != $past(card_route)) |-> $past(w_func, 2));

    // R6: every error pulse follows a bad access
    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(a_bad));

    // R9: read data is zero unless it answers a read
    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind pinbank_regs pinbank_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .pin_out    (pin_out),
    .card_route (card_route)
);

// File: tb/pinbank_regs_test.sv
// Scoreboard bench: access tasks queue expected responses, a monitor compares.
module pinbank_regs_test;

    localparam int NP = 54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [NP-1:0] pin_out;
    logic        card_route;

    always #2 clk = ~clk;

    pinbank_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_out(pin_out), .card_route(card_route)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] rdata;
        bit          err;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          acc_seen = 0;
    bit          done = 0;

    int          m_code[NP];
    bit          m_lev[NP];
    logic [NP-1:0] m_out = '0;
    bit          m_route = 0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: after each access edge, pop and compare the response.
    always @(posedge clk) acc_seen <= bus_rd | bus_wr;
    always @(negedge clk) begin
        if (acc_seen) begin
            if (sb.size() == 0) begin
                check("SB", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_rd) check(e.tag, "rdata", 64'(bus_rdata), 64'(e.rdata));
                check(e.tag, "err", 64'(bus_err), 64'(e.err));
            end
        end
    end

    task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [31:0] exp_rd, input bit exp_err, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
        e.is_rd = !wr; e.rdata = exp_rd; e.err = exp_err; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1 bus_wr = 0; bus_rd = 0;
    endtask

    function automatic logic [31:0] func_word(input int r);
        logic [31:0] w = '0;
        for (int i = 0; i < 10; i++)
            if (r*10 + i < NP) w[3*i +: 3] = 3'(m_code[r*10 + i]);
        return w;
    endfunction

    function automatic logic [31:0] lev_word(input int bank);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++)
            if (bank*32 + i < NP) w[i] = m_lev[bank*32 + i];
        return w;
    endfunction

    function automatic void route_model();
        bit all_a = 1, all_b = 1;
        for (int p = 48; p < 54; p++) begin
            if (m_code[p] != 0) all_a = 0;
            if (m_code[p] != 4) all_b = 0;
        end
        if (all_a) m_route = 0;
        else if (all_b) m_route = 1;
    endfunction

    task automatic wr_func_raw(input int r, input logic [31:0] d, input string tag);
        for (int i = 0; i < 10; i++)
            if (r*10 + i < NP) m_code[r*10 + i] = int'(d[3*i +: 3]);
        route_model();
        access(1, 12'(r*4), d, '0, 0, tag);
    endtask

    task automatic set_code(input int pin, input int code, input string tag);
        m_code[pin] = code;
        route_model();
        access(1, 12'((pin/10)*4), func_word(pin/10), '0, 0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input bit err, input string tag);
        access(0, a, '0, exp, err, tag);
    endtask

    task automatic chk_out(input string tag);
        @(negedge clk);
        check(tag, "pin_out", 64'(pin_out), 64'(m_out));
    endtask

    task automatic chk_route(input string tag);
        @(negedge clk);
        @(negedge clk);
        check(tag, "card_route", 64'(card_route), 64'(m_route));
    endtask

    task automatic wr_set(input int bank, input logic [31:0] v, input string tag);
        for (int i = 0; i < 32; i++) begin
            int p = bank*32 + i;
            if (p < NP && v[i]) begin
                if (!m_lev[p] && m_code[p] == 1) m_out[p] = 1'b1;
                m_lev[p] = 1;
            end
        end
        access(1, bank ? 12'h020 : 12'h01C, v, '0, 0, tag);
        chk_out(tag);
    endtask

    task automatic wr_clr(input int bank, input logic [31:0] v, input string tag);
        for (int i = 0; i < 32; i++) begin
            int p = bank*32 + i;
            if (p < NP && v[i]) begin
                if (m_lev[p] && m_code[p] == 1) m_out[p] = 1'b0;
                m_lev[p] = 0;
            end
        end
        access(1, bank ? 12'h02C : 12'h028, v, '0, 0, tag);
        chk_out(tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin m_code[p] = 0; m_lev[p] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        for (int r = 0; r < 6; r++) rd(12'(r*4), 32'h0, 0, "R8 codes");
        rd(12'h034, 32'h0, 0, "R8 lev0");
        rd(12'h038, 32'h0, 0, "R8 lev1");
        chk_out("R8");
        check("R8", "card_route", 64'(card_route), 64'd0);

        // R1: packing, top bits and missing fields
        wr_func_raw(1, 32'hDEADBEEF, "R1 word1");
        rd(12'h004, 32'h1EADBEEF, 0, "R1 word1");
        wr_func_raw(5, 32'hFFFFFFFF, "R1 word5");
        rd(12'h014, 32'h00000FFF, 0, "R1 word5");
        wr_func_raw(0, 32'h3FFFFFFF, "R1 word0");
        rd(12'h000, func_word(0), 0, "R1 word0");
        wr_func_raw(0, 32'h0, "R1 word0 clear");
        rd(12'h000, 32'h0, 0, "R1 word0 clear");
        chk_route("R7 mixed after codes 7");

        // R9: data returns to zero after the read response
        @(negedge clk);
        check("R9", "idle rdata", 64'(bus_rdata), 64'd0);

        // R2 / R4: set on output and input pins
        set_code(3, 1, "R4 cfg");
        wr_set(0, 32'h18, "R2 R4 set 3,4");
        rd(12'h034, lev_word(0), 0, "R2 lev0");
        rd(12'h01C, 32'h0, 0, "R2 set port reads 0");
        rd(12'h028, 32'h0, 0, "R2 clr port reads 0");
        // R4: pin 4 already high, becoming output then set again: no movement
        set_code(4, 1, "R4 cfg");
        wr_set(0, 32'h10, "R4 no level change");
        wr_clr(0, 32'h10, "R4 clear pin4");
        wr_set(0, 32'h10, "R4 set pin4");
        wr_clr(0, 32'h08, "R4 clear pin3");
        set_code(4, 0, "R4 cfg input");
        wr_clr(0, 32'h10, "R4 input holds output");
        rd(12'h034, lev_word(0), 0, "R2 lev0 after clears");

        // R2 / R3: upper bank masking and read-only levels
        set_code(33, 1, "R4 cfg 33");
        wr_set(1, 32'hFFFFFFFF, "R2 bank1 set");
        rd(12'h038, 32'h003FFFFF, 0, "R3 lev1");
        access(1, 12'h038, 32'h0, '0, 0, "R3 write lev1");
        access(1, 12'h034, 32'hFFFFFFFF, '0, 0, "R3 write lev0");
        rd(12'h038, 32'h003FFFFF, 0, "R3 lev1 unchanged");
        rd(12'h034, lev_word(0), 0, "R3 lev0 unchanged");
        wr_clr(1, 32'hFFC00003, "R2 bank1 clear");
        rd(12'h038, lev_word(1), 0, "R2 lev1 after clear");

        // R5: inert slots
        access(1, 12'h040, 32'hFFFFFFFF, '0, 0, "R5 write 0x40");
        access(1, 12'h094, 32'hFFFFFFFF, '0, 0, "R5 write 0x94");
        access(1, 12'h08C, 32'hFFFFFFFF, '0, 0, "R5 write 0x8C");
        rd(12'h040, 32'h0, 0, "R5 read 0x40");
        rd(12'h09C, 32'h0, 0, "R5 read 0x9C");
        rd(12'h070, 32'h0, 0, "R5 read 0x70");
        rd(12'h034, lev_word(0), 0, "R5 lev0 untouched");
        chk_out("R5");

        // R6: bad slots
        rd(12'h018, 32'h0, 1, "R6 read 0x18");
        rd(12'h048, 32'h0, 1, "R6 read 0x48");
        rd(12'h03C, 32'h0, 1, "R6 read 0x3C");
        rd(12'h200, 32'h0, 1, "R6 read 0x200");
        rd(12'h005, 32'h0, 1, "R6 read unaligned");
        access(1, 12'h018, 32'hFFFFFFFF, '0, 1, "R6 write 0x18");
        access(1, 12'h024, 32'hFFFFFFFF, '0, 1, "R6 write 0x24");
        access(1, 12'h01E, 32'hFFFFFFFF, '0, 1, "R6 write unaligned");
        rd(12'h034, lev_word(0), 0, "R6 lev0 untouched");
        rd(12'h038, lev_word(1), 0, "R6 lev1 untouched");
        rd(12'h014, func_word(5), 0, "R6 codes untouched");
        chk_out("R6");

        // R7: route selection
        set_code(48, 4, "R7 cfg");
        set_code(49, 4, "R7 cfg");
        chk_route("R7 mixed stays A");
        wr_func_raw(5, 32'h00000924, "R7 all four");
        chk_route("R7 switch to B");
        set_code(50, 0, "R7 cfg");
        chk_route("R7 mixed stays B");
        set_code(48, 0, "R7 cfg");
        set_code(49, 0, "R7 cfg");
        chk_route("R7 still mixed");
        wr_func_raw(5, 32'h0, "R7 all zero");
        chk_route("R7 back to A");
        wr_func_raw(5, 32'h0, "R7 repeat zero");
        chk_route("R7 repeat stays A");

        repeat (3) @(negedge clk);
        check("SB", "drained", 64'(sb.size()), 64'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule